// File: doc/BRIEF.md
# Two-Way Mailbox With Per-Byte Full Flags

This block passes 32-bit words between a host-bus port and a local-bus port that share one clock. Each port owns an outbound mailbox that only it can write. The other port reads that same mailbox as its inbound mailbox. Every byte of both mailboxes carries its own full flag. Writing a byte marks it full, and a consuming read of that byte empties it. Either port can watch the flags through a shared read-only status word, so software can poll before it overwrites data or reads stale data.

Every access carries per-byte enables. A narrow local master can therefore fill or drain the four bytes one lane at a time. Each port also has a write-only control register with a flag-clear bit. That bit empties every flag seen from both ports at once, and it leaves the mailbox contents untouched.

Both front ends are plain synchronous register ports. A request is `sel` high for one cycle, with `wen` choosing a write or a read. Read data is registered: it appears on the cycle after the request and is held until the next read on that port.

Top module: `dual_mailbox_top`

## Requirements
- R1: After reset, both mailboxes hold zero, all eight flags are empty and both read-data outputs are zero.
- R2: A write at offset 0 updates only the bytes of the port's outbound mailbox whose enables are high. A read at offset 0 returns the whole outbound word and changes no flag.
- R3: Each enabled byte written at offset 0 sets its flag. The status word at offset 2 carries the host-to-local flags in bits [3:0] and the local-to-host flags in bits [7:4], with bit n of each nibble meaning byte n. Bits above 7 read as zero, and both ports read the same value.
- R4: A read at offset 1 returns the whole inbound word (the other port's outbound mailbox). It empties the flags of the enabled bytes that were full.
- R5: Reading an empty inbound byte returns its last written value and leaves its flag empty.
- R6: Writes at offset 1 (inbound) and offset 2 (status) change neither mailbox data nor any flag.
- R7: A write at offset 3 with byte enable 0 high and data bit 0 equal to 1, from either port, empties all eight flags at the next clock edge. The clear takes priority over a write landing in the same cycle, whose data is still stored. Writing 0 has no effect. Offset 3 reads as zero.
- R8: If one port writes a byte and the other port reads that byte as inbound in the same cycle, the read returns the old data, the new data is stored and the flag ends up full.
- R9: Read data changes only on the cycle after a read request and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 1 | Host access request |
| host_wen | input | 1 | Host access is a write when high |
| host_addr | input | 2 | Host register offset |
| host_ben | input | 4 | Host byte enables |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| loc_sel | input | 1 | Local access request |
| loc_wen | input | 1 | Local access is a write when high |
| loc_addr | input | 2 | Local register offset |
| loc_ben | input | 4 | Local byte enables |
| loc_wdata | input | 32 | Local write data |
| loc_rdata | output | 32 | Local read data, registered |

## Verification
The hardest states to reach are those where both ports act on the same byte in the same cycle. One case is a producer write racing a consumer read. The other is a flag clear from one port landing together with a data write from the other. Neither case can be reached with one port at a time, so the bench drives both ports in a single step and updates its model in a fixed order: reads sample old data, then the clear beats the set and the set beats the read-clear. The main sweep covers all 16 write-enable patterns against all 16 read-enable patterns in both directions. This reaches every mix of full and empty bytes under a consuming read.

// File: rtl/mbox_pkg.sv
// Package: shared register map for the two-way mailbox.
// Assumes a fixed four-entry map per port, so the offset width is fixed here.
package mbox_pkg;

    localparam int unsigned MBOX_ADDR_W = 2;

    // Register offsets seen by each port; the order is the decoder's contract.
    typedef enum logic [MBOX_ADDR_W-1:0] {
        REG_OUTBOX  = 2'd0,
        REG_INBOX   = 2'd1,
        REG_STATUS  = 2'd2,
        REG_CONTROL = 2'd3
    } mbox_reg_e;

    // Bit of the control word that empties every flag.
    localparam int unsigned CTRL_CLEAR_BIT = 0;

endpackage

// File: rtl/mbox_side_decode.sv
// Module: mbox_side_decode
// Turns one port's request into per-byte strobes: outbound writes,
// consuming inbound reads, the flag-clear pulse and the read-mux select.
// Assumes one request per cycle per port (sel with wen choosing direction).
module mbox_side_decode
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned DATA_W   = NUM_BYTES * 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_i,
    input  logic                   wen_i,
    input  logic [MBOX_ADDR_W-1:0] addr_i,
    input  logic [NUM_BYTES-1:0]   ben_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [NUM_BYTES-1:0]   out_wr_be_o,
    output logic [NUM_BYTES-1:0]   in_rd_be_o,
    output logic                   flush_o,
    output logic                   rd_fire_o,
    output mbox_reg_e              rsel_o
);

    mbox_reg_e reg_sel;
    logic      is_wr;
    logic      is_rd;

    // Purpose: split the request into a write or a read at a named register.
    always_comb begin
        reg_sel = mbox_reg_e'(addr_i);
        is_wr   = sel_i && wen_i;
        is_rd   = sel_i && !wen_i;
    end

    // Purpose: produce the per-byte and whole-block strobes.
    always_comb begin
        out_wr_be_o = (is_wr && reg_sel == REG_OUTBOX) ? ben_i : '0;
        in_rd_be_o  = (is_rd && reg_sel == REG_INBOX)  ? ben_i : '0;
        flush_o     = is_wr && (reg_sel == REG_CONTROL) && ben_i[0]
                      && wdata_i[CTRL_CLEAR_BIT];
        rd_fire_o   = is_rd;
        rsel_o      = reg_sel;
    end

    // At most one kind of action leaves the decoder in a cycle (R6 / R7).
    p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({|out_wr_be_o, |in_rd_be_o, flush_o}));

    // A read request never produces a write-side strobe (R9).
    p_read_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_fire_o |-> (out_wr_be_o == '0 && !flush_o));

endmodule

// File: rtl/mbox_lane.sv
// Module: mbox_lane
// One mailbox byte and its full flag. Priority of flag updates:
// clear-all first, then a write (sets), then a consuming read (empties).
// Data is stored on any write, including one that meets a clear-all.
module mbox_lane #(
    parameter int unsigned LANE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic              clr_i,
    input  logic              flush_i,
    input  logic [LANE_W-1:0] wdata_i,
    output logic [LANE_W-1:0] data_o,
    output logic              full_o
);

    logic [LANE_W-1:0] data_q;
    logic              full_q;

    // Purpose: capture the byte whenever its producer writes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (set_i) begin
            data_q <= wdata_i;
        end
    end

    // Purpose: track full/empty with clear-all > write > consuming read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
        end else if (flush_i) begin
            full_q <= 1'b0;
        end else if (set_i) begin
            full_q <= 1'b1;
        end else if (clr_i) begin
            full_q <= 1'b0;
        end
    end

    assign data_o = data_q;
    assign full_o = full_q;

    // A write that is not cleared leaves the byte full (R3, R8).
    p_write_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i) |=> full_o);

    // A consuming read without a competing write empties the byte (R4).
    p_read_drains_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !flush_i) |=> !full_o);

    // Reading an empty byte keeps it empty and keeps its data (R5).
    p_empty_read_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i && !full_o) |=> (!full_o && $stable(data_o)));

    // Clear-all empties the flag regardless of other activity (R7).
    p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !full_o);

    // Without a write, the stored byte does not move (R2).
    p_idle_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !set_i |=> $stable(data_o));

    // Without any cause, the flag does not move (R6).
    p_flag_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i && !flush_i) |=> $stable(full_o));

endmodule

// File: rtl/mbox_channel.sv
// Module: mbox_channel
// One direction of the mailbox: a row of byte lanes written by the
// producer port and drained by the consumer port.
module mbox_channel #(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned DATA_W   = NUM_BYTES * 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] wr_be_i,
    input  logic [NUM_BYTES-1:0] rd_be_i,
    input  logic                 flush_i,
    input  logic [DATA_W-1:0]    wdata_i,
    output logic [DATA_W-1:0]    data_o,
    output logic [NUM_BYTES-1:0] full_o
);

    genvar g;
    generate
        for (g = 0; g < NUM_BYTES; g++) begin : g_lane
            mbox_lane #(
                .LANE_W (8)
            ) lane_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_i   (wr_be_i[g]),
                .clr_i   (rd_be_i[g]),
                .flush_i (flush_i),
                .wdata_i (wdata_i[g*8 +: 8]),
                .data_o  (data_o[g*8 +: 8]),
                .full_o  (full_o[g])
            );
        end
    endgenerate

endmodule

// File: rtl/mbox_read_port.sv
// Module: mbox_read_port
// Registered read mux for one port. Output updates only on a read request
// and then holds, so a master can sample it any time before its next read.
module mbox_read_port
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned DATA_W   = NUM_BYTES * 8,
    localparam int unsigned STAT_W   = 2 * NUM_BYTES,
    localparam int unsigned PAD_W    = DATA_W - STAT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_fire_i,
    input  mbox_reg_e         rsel_i,
    input  logic [DATA_W-1:0] outbox_i,
    input  logic [DATA_W-1:0] inbox_i,
    input  logic [STAT_W-1:0] status_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] mux_word;
    logic [DATA_W-1:0] rdata_q;

    // Purpose: pick the word addressed by the current read.
    always_comb begin
        unique case (rsel_i)
            REG_OUTBOX:  mux_word = outbox_i;
            REG_INBOX:   mux_word = inbox_i;
            REG_STATUS:  mux_word = {{PAD_W{1'b0}}, status_i};
            default:     mux_word = '0;
        endcase
    end

    // Purpose: register the selected word on a read, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_fire_i) begin
            rdata_q <= mux_word;
        end
    end

    assign rdata_o = rdata_q;

    // Read data moves only after a read request (R9).
    p_hold_when_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire_i |=> $stable(rdata_o));

    // The control register reads back as zero (R7).
    p_ctrl_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire_i && rsel_i == REG_CONTROL) |=> (rdata_o == '0));

endmodule

// File: rtl/dual_mailbox_top.sv
// Module: dual_mailbox_top
// Two-way mailbox between a host port and a local port on one clock.
// Host outbound = local inbound (channel h2l); local outbound = host
// inbound (channel l2h). Status word: h2l flags low, l2h flags high.
// A flag-clear from either port empties both channels.
module dual_mailbox_top
    import mbox_pkg::*;
#(
    parameter int unsigned NUM_BYTES = 4,
    localparam int unsigned DATA_W   = NUM_BYTES * 8,
    localparam int unsigned STAT_W   = 2 * NUM_BYTES
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_sel,
    input  logic                   host_wen,
    input  logic [MBOX_ADDR_W-1:0] host_addr,
    input  logic [NUM_BYTES-1:0]   host_ben,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic [DATA_W-1:0]      host_rdata,
    input  logic                   loc_sel,
    input  logic                   loc_wen,
    input  logic [MBOX_ADDR_W-1:0] loc_addr,
    input  logic [NUM_BYTES-1:0]   loc_ben,
    input  logic [DATA_W-1:0]      loc_wdata,
    output logic [DATA_W-1:0]      loc_rdata
);

    logic [NUM_BYTES-1:0] host_wr_be, host_rd_be;
    logic [NUM_BYTES-1:0] loc_wr_be,  loc_rd_be;
    logic                 host_flush, loc_flush, flush_all;
    logic                 host_rd_fire, loc_rd_fire;
    mbox_reg_e            host_rsel, loc_rsel;
    logic [DATA_W-1:0]    h2l_data, l2h_data;
    logic [NUM_BYTES-1:0] h2l_full, l2h_full;
    logic [STAT_W-1:0]    status_word;

    mbox_side_decode #(.NUM_BYTES(NUM_BYTES)) host_dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (host_sel),
        .wen_i       (host_wen),
        .addr_i      (host_addr),
        .ben_i       (host_ben),
        .wdata_i     (host_wdata),
        .out_wr_be_o (host_wr_be),
        .in_rd_be_o  (host_rd_be),
        .flush_o     (host_flush),
        .rd_fire_o   (host_rd_fire),
        .rsel_o      (host_rsel)
    );

    mbox_side_decode #(.NUM_BYTES(NUM_BYTES)) loc_dec_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (loc_sel),
        .wen_i       (loc_wen),
        .addr_i      (loc_addr),
        .ben_i       (loc_ben),
        .wdata_i     (loc_wdata),
        .out_wr_be_o (loc_wr_be),
        .in_rd_be_o  (loc_rd_be),
        .flush_o     (loc_flush),
        .rd_fire_o   (loc_rd_fire),
        .rsel_o      (loc_rsel)
    );

    // Purpose: merge both ports' clear requests and build the shared status.
    always_comb begin
        flush_all   = host_flush | loc_flush;
        status_word = {l2h_full, h2l_full};
    end

    // Host-to-local channel: host writes, local drains.
    mbox_channel #(.NUM_BYTES(NUM_BYTES)) h2l_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be_i (host_wr_be),
        .rd_be_i (loc_rd_be),
        .flush_i (flush_all),
        .wdata_i (host_wdata),
        .data_o  (h2l_data),
        .full_o  (h2l_full)
    );

    // Local-to-host channel: local writes, host drains.
    mbox_channel #(.NUM_BYTES(NUM_BYTES)) l2h_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_be_i (loc_wr_be),
        .rd_be_i (host_rd_be),
        .flush_i (flush_all),
        .wdata_i (loc_wdata),
        .data_o  (l2h_data),
        .full_o  (l2h_full)
    );

    mbox_read_port #(.NUM_BYTES(NUM_BYTES)) host_rp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fire_i (host_rd_fire),
        .rsel_i    (host_rsel),
        .outbox_i  (h2l_data),
        .inbox_i   (l2h_data),
        .status_i  (status_word),
        .rdata_o   (host_rdata)
    );

    mbox_read_port #(.NUM_BYTES(NUM_BYTES)) loc_rp_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_fire_i (loc_rd_fire),
        .rsel_i    (loc_rsel),
        .outbox_i  (l2h_data),
        .inbox_i   (h2l_data),
        .status_i  (status_word),
        .rdata_o   (loc_rdata)
    );

    // Both ports reading status together see the same word (R3).
    p_shared_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_fire && loc_rd_fire && host_rsel == REG_STATUS
         && loc_rsel == REG_STATUS) |=> (host_rdata == loc_rdata));

    // A clear from either port leaves every flag empty (R7).
    p_clear_both_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (h2l_full == '0 && l2h_full == '0));

endmodule

// File: tb/dual_mailbox_top_tb_top.sv
// Bench: drives both ports in lockstep and compares registered read data
// against a byte-level model built from the requirements.
module dual_mailbox_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0, host_wen = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [3:0]  host_ben = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        loc_sel = 1'b0, loc_wen = 1'b0;
    logic [1:0]  loc_addr = '0;
    logic [3:0]  loc_ben = '0;
    logic [31:0] loc_wdata = '0;
    logic [31:0] loc_rdata;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // Model: mb[0] = host outbound (h2l), mb[1] = local outbound (l2h).
    logic [7:0]  mb [2][4];
    logic        fl [2][4];
    logic [31:0] exp_rd [2];

    always #2 clk = ~clk;

    dual_mailbox_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wen   (host_wen),
        .host_addr  (host_addr),
        .host_ben   (host_ben),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .loc_sel    (loc_sel),
        .loc_wen    (loc_wen),
        .loc_addr   (loc_addr),
        .loc_ben    (loc_ben),
        .loc_wdata  (loc_wdata),
        .loc_rdata  (loc_rdata)
    );

    function automatic logic [31:0] pack_box(input int m);
        return {mb[m][3], mb[m][2], mb[m][1], mb[m][0]};
    endfunction

    function automatic logic [31:0] model_read(input int s, input logic [1:0] a);
        logic [31:0] st;
        st = '0;
        for (int b = 0; b < 4; b++) begin
            st[b]     = fl[0][b];
            st[4 + b] = fl[1][b];
        end
        case (a)
            2'd0:    return pack_box(s);
            2'd1:    return pack_box(1 - s);
            2'd2:    return st;
            default: return '0;
        endcase
    endfunction

    task automatic check(input string tag, input int s, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s port%0d rdata=%h expected=%h", tag, s, act, exp);
        end
    endtask

    // One lockstep cycle on both ports; model updated in requirement order.
    task automatic step(input logic hs, input logic hw, input logic [1:0] ha,
                        input logic [3:0] hb, input logic [31:0] hd,
                        input logic ls, input logic lw, input logic [1:0] la,
                        input logic [3:0] lb, input logic [31:0] ld,
                        input string tag);
        logic        cs [2];
        logic        we [2];
        logic [1:0]  ad [2];
        logic [3:0]  be [2];
        logic [31:0] wd [2];
        logic        flush;
        logic        setb [2][4];
        logic        clrb [2][4];
        cs[0] = hs; we[0] = hw; ad[0] = ha; be[0] = hb; wd[0] = hd;
        cs[1] = ls; we[1] = lw; ad[1] = la; be[1] = lb; wd[1] = ld;
        @(negedge clk);
        host_sel = hs; host_wen = hw; host_addr = ha; host_ben = hb; host_wdata = hd;
        loc_sel  = ls; loc_wen  = lw; loc_addr  = la; loc_ben  = lb; loc_wdata  = ld;
        // reads see pre-edge state (R8, R9)
        for (int s = 0; s < 2; s++)
            if (cs[s] && !we[s]) exp_rd[s] = model_read(s, ad[s]);
        flush = 1'b0;
        for (int s = 0; s < 2; s++)
            if (cs[s] && we[s] && ad[s] == 2'd3 && be[s][0] && wd[s][0]) flush = 1'b1;
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 4; b++) begin
                setb[m][b] = cs[m] && we[m] && ad[m] == 2'd0 && be[m][b];
                clrb[m][b] = cs[1-m] && !we[1-m] && ad[1-m] == 2'd1 && be[1-m][b];
            end
        for (int m = 0; m < 2; m++)
            for (int b = 0; b < 4; b++) begin
                if (setb[m][b]) mb[m][b] = wd[m][b*8 +: 8];
                if (flush)           fl[m][b] = 1'b0;
                else if (setb[m][b]) fl[m][b] = 1'b1;
                else if (clrb[m][b]) fl[m][b] = 1'b0;
            end
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; loc_sel = 1'b0;
        check(tag, 0, host_rdata, exp_rd[0]);
        check(tag, 1, loc_rdata,  exp_rd[1]);
    endtask

    task automatic rd_status(input string tag);
        step(1, 0, 2'd2, 4'hF, '0, 1, 0, 2'd2, 4'hF, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int m = 0; m < 2; m++) begin
            exp_rd[m] = '0;
            for (int b = 0; b < 4; b++) begin
                mb[m][b] = '0;
                fl[m][b] = 1'b0;
            end
        end
        repeat (3) @(negedge clk);
        // R1: outputs zero while and just after reset
        check("R1 reset rdata", 0, host_rdata, 32'h0);
        check("R1 reset rdata", 1, loc_rdata, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_status("R1 status after reset");
        step(1, 0, 2'd0, 4'hF, '0, 1, 0, 2'd1, 4'hF, '0, "R1 mailboxes after reset");

        // R2..R5, R7: all write-enable x read-enable patterns in both directions
        for (int dir = 0; dir < 2; dir++)
            for (int bw = 0; bw < 16; bw++)
                for (int br = 0; br < 16; br++) begin
                    logic [31:0] d;
                    d = {8'(8'h10 + bw), 8'(8'h20 + br), 8'(8'h30 + dir), 8'(8'h40 + bw + br)};
                    if (bw[0]) step(1, 1, 2'd3, 4'h1, 32'h1, 0, 0, 2'd0, 4'h0, '0, "R7 clear host");
                    else       step(0, 0, 2'd0, 4'h0, '0, 1, 1, 2'd3, 4'h1, 32'h1, "R7 clear local");
                    if (dir == 0) step(1, 1, 2'd0, 4'(bw), d, 0, 0, 2'd0, 4'h0, '0, "R2 R3 host write");
                    else          step(0, 0, 2'd0, 4'h0, '0, 1, 1, 2'd0, 4'(bw), d, "R2 R3 local write");
                    rd_status("R3 status after write");
                    if (dir == 0) step(0, 0, 2'd0, 4'h0, '0, 1, 0, 2'd1, 4'(br), '0, "R4 R5 local drain");
                    else          step(1, 0, 2'd1, 4'(br), '0, 0, 0, 2'd0, 4'h0, '0, "R4 R5 host drain");
                    rd_status("R4 R5 status after drain");
                    step(1, 0, 2'd0, 4'hF, '0, 1, 0, 2'd0, 4'hF, '0, "R2 own outbox read");
                end

        // R6: writes to inbound and status offsets are ignored
        step(1, 1, 2'd0, 4'hF, 32'hCAFE_F00D, 1, 1, 2'd0, 4'hF, 32'h1234_5678, "R6 setup");
        step(1, 1, 2'd1, 4'hF, 32'hFFFF_FFFF, 1, 1, 2'd2, 4'hF, 32'h0, "R6 ignored writes");
        step(1, 1, 2'd2, 4'hF, 32'h0, 1, 1, 2'd1, 4'hF, 32'h0, "R6 ignored writes");
        rd_status("R6 status unchanged");
        step(1, 0, 2'd1, 4'h0, '0, 1, 0, 2'd1, 4'h0, '0, "R6 data unchanged");

        // R7: writing 0, or clear bit without byte enable 0, does nothing; offset 3 reads 0
        step(1, 1, 2'd3, 4'hF, 32'h0, 1, 1, 2'd3, 4'hE, 32'hFFFF_FFFF, "R7 no-op clears");
        rd_status("R7 flags kept");
        step(1, 0, 2'd3, 4'hF, '0, 1, 0, 2'd3, 4'hF, '0, "R7 control reads zero");

        // R7: clear from host races a local write; data kept, flags empty
        step(1, 1, 2'd3, 4'h1, 32'h1, 1, 1, 2'd0, 4'h6, 32'hAABB_CCDD, "R7 clear beats write");
        rd_status("R7 status after race");
        step(1, 0, 2'd1, 4'h0, '0, 0, 0, 2'd0, 4'h0, '0, "R7 race data stored");

        // R8: local write and host inbound read hit the same bytes together
        step(0, 0, 2'd0, 4'h0, '0, 1, 1, 2'd0, 4'h3, 32'h0000_5566, "R8 fill");
        step(1, 0, 2'd1, 4'hF, '0, 1, 1, 2'd0, 4'h5, 32'h7700_8800, "R8 collision read old");
        rd_status("R8 write wins flag");
        step(1, 0, 2'd1, 4'h0, '0, 0, 0, 2'd0, 4'h0, '0, "R8 new data stored");

        // R9: idle and write cycles hold read data
        step(0, 0, 2'd0, 4'h0, '0, 0, 0, 2'd0, 4'h0, '0, "R9 hold idle");
        step(1, 1, 2'd0, 4'hF, 32'h0BAD_0BAD, 1, 1, 2'd0, 4'hF, 32'h600D_600D, "R9 hold on write");

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule